// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block generates the reset for a processor from three digital causes. The first is an undervoltage flag from an external comparator. The second is a push-button manual reset that is active low. The third is a watchdog that the processor must keep alive by toggling a pin. Whenever any cause is present, reset is asserted. After the last cause clears, reset is held for a fixed stretch period so that supplies and clocks can settle. Reset is driven out as a complementary pair: one active-high output and one active-low output.

The manual reset and watchdog inputs are asynchronous to the block, so each passes through a two-flop synchronizer. A low level on the manual reset input counts only after it has been held for a programmable number of cycles. Shorter dips are discarded as noise. Both edges of the watchdog input restart the watchdog count. While reset is asserted, the watchdog is held at zero, and it begins counting again only once reset has released. A watchdog-enable input stands in for a watchdog pin that is left undriven; while it is low, the watchdog never fires. The block's own power-on reset starts it with reset asserted, and the first release comes after one full stretch period.

Top module: `rst_supervisor`

## Requirements
- R1: While `por_n` is low, `rst_hi` is 1 and `rst_lo` is 0. After `por_n` rises, `rst_hi` stays high for exactly STRETCH_CYC rising clock edges and then falls.
- R2: `uv_flag` high at a rising edge makes `rst_hi` high after that edge.
- R3: After `uv_flag` returns low, `rst_hi` stays high for exactly STRETCH_CYC further edges and then falls.
- R4: `mr_n` held low for GLITCH_CYC cycles or more asserts reset. When `mr_n` is held low, `rst_hi` rises on the (GLITCH_CYC+3)th edge after `mr_n` falls; this count includes the two synchronizer stages.
- R5: A low pulse on `mr_n` that is shorter than GLITCH_CYC cycles never asserts reset.
- R6: After `mr_n` returns high, `rst_hi` falls on the (STRETCH_CYC+3)th edge.
- R7: With the watchdog enabled and never serviced, reset stays low for exactly WDOG_CYC cycles after each release. Reset is then high for exactly STRETCH_CYC cycles, and this pattern repeats.
- R8: Each rising and each falling transition on `wd_kick` restarts the watchdog. Transitions spaced WDOG_CYC cycles apart or closer prevent any reset. A spacing larger than WDOG_CYC produces a reset.
- R9: The watchdog is held cleared while reset is asserted from any cause. After every release it grants a full WDOG_CYC window.
- R10: While `wd_en` is low, no watchdog reset ever occurs.
- R11: `rst_lo` is always the inverse of `rst_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Block power-on reset, asynchronous, active low |
| uv_flag | input | 1 | Undervoltage flag, synchronous, active high |
| mr_n | input | 1 | Manual reset request, asynchronous, active low |
| wd_kick | input | 1 | Watchdog service input; either transition services the watchdog |
| wd_en | input | 1 | Watchdog enable; low means the watchdog pin is undriven |
| rst_hi | output | 1 | Processor reset, active high |
| rst_lo | output | 1 | Processor reset, active low |

## Verification
Watchdog service is exercised by a table of toggle spacings. The spacings lie below, at, and one cycle past the timeout, plus one far past it, so the boundary between "kept alive" and "reset" is pinned to a single cycle. Manual reset is tried with a dip one cycle shorter than the filter and with a dip exactly as long as the filter, which tells a correct filter length apart from an off-by-one error. Exact cycle counts for assertion and release on each cause separate the shared stretch timer from the per-path synchronizer latency. An undervoltage pulse that lands midway through a watchdog window checks that the window restarts in full rather than resuming.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int STRETCH_CYC = 200000,
  parameter int WDOG_CYC    = 80000000,
  parameter int GLITCH_CYC  = 5
) (
  input  logic clk,
  input  logic por_n,
  input  logic uv_flag,
  input  logic mr_n,
  input  logic wd_kick,
  input  logic wd_en,
  output logic rst_hi,
  output logic rst_lo
);
  localparam int SW = $clog2(STRETCH_CYC + 1);
  localparam int WW = $clog2(WDOG_CYC + 1);
  localparam int GW = $clog2(GLITCH_CYC + 1);

  logic [1:0]    mr_sync;
  logic [2:0]    wd_sync;
  logic [GW-1:0] gl_cnt;
  logic [WW-1:0] wd_cnt;
  logic [SW-1:0] str_cnt, str_nxt;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      mr_sync <= '1;
      wd_sync <= '0;
    end else begin
      mr_sync <= {mr_sync[0], mr_n};
      wd_sync <= {wd_sync[1:0], wd_kick};
    end

  wire mr_low   = !mr_sync[1];
  wire mr_valid = (gl_cnt == GW'(GLITCH_CYC));
  wire wd_edge  = wd_sync[2] ^ wd_sync[1];
  wire wd_fire  = wd_en && !rst_hi && !wd_edge && (wd_cnt == WW'(WDOG_CYC - 1));
  wire cause    = uv_flag || mr_valid || wd_fire;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)          gl_cnt <= '0;
    else if (!mr_low)    gl_cnt <= '0;
    else if (!mr_valid)  gl_cnt <= gl_cnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                                      wd_cnt <= '0;
    else if (rst_hi || !wd_en || wd_edge || wd_fire) wd_cnt <= '0;
    else                                             wd_cnt <= wd_cnt + 1'b1;

  always_comb
    if (cause)               str_nxt = SW'(STRETCH_CYC);
    else if (str_cnt != '0)  str_nxt = str_cnt - 1'b1;
    else                     str_nxt = '0;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      str_cnt <= SW'(STRETCH_CYC);
      rst_hi  <= 1'b1;
      rst_lo  <= 1'b0;
    end else begin
      str_cnt <= str_nxt;
      rst_hi  <= (str_nxt != '0);
      rst_lo  <= (str_nxt == '0);
    end

  // R2
  uv_assert_chk: assert property (@(posedge clk) disable iff (!por_n)
    uv_flag |=> rst_hi);

  // R3
  uv_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(uv_flag) |=> rst_hi);

  // R9
  wd_held_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rst_hi && $past(rst_hi)) |-> (wd_cnt == '0));

  // R10
  wd_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    !wd_en |=> (wd_cnt == '0));

  // R4
  mr_valid_chk: assert property (@(posedge clk) disable iff (!por_n)
    mr_valid |=> rst_hi);

  // R11
  compl_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_hi != rst_lo);
endmodule

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
  localparam int S = 10;
  localparam int W = 24;
  localparam int G = 5;

  logic clk = 1'b0;
  logic por_n = 1'b0, uv_flag = 1'b0, mr_n = 1'b1, wd_kick = 1'b0, wd_en = 1'b0;
  logic rst_hi, rst_lo;
  int total = 0, bad = 0, compl_bad = 0;

  rst_supervisor #(.STRETCH_CYC(S), .WDOG_CYC(W), .GLITCH_CYC(G)) dut (
    .clk(clk), .por_n(por_n), .uv_flag(uv_flag), .mr_n(mr_n),
    .wd_kick(wd_kick), .wd_en(wd_en), .rst_hi(rst_hi), .rst_lo(rst_lo));

  always #10 clk = ~clk;

  // spacing between kick transitions, and whether a reset is expected
  localparam int NV = 6;
  localparam int GAP [NV] = '{4, 12, W-1, W, W+1, 40};
  localparam bit HIT [NV] = '{0, 0, 0, 0, 1, 1};

  task automatic tick();
    @(posedge clk); #2;
    if (rst_hi === rst_lo) compl_bad++;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (rst_hi) begin n++; tick(); end
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!rst_hi) begin n++; tick(); end
  endtask

  task automatic uv_pulse();
    uv_flag = 1'b1; tick(); tick(); uv_flag = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    bit seen;
    repeat (3) @(posedge clk);
    #2;
    check(rst_hi === 1'b1 && rst_lo === 1'b0, "R1 reset state", rst_hi, 1);

    por_n = 1'b1;
    n = 0;
    while (rst_hi) begin tick(); n++; end
    check(n == S, "R1 power-on stretch", n, S);
    check(rst_lo === 1'b1, "R11 released low output", rst_lo, 1);

    repeat (3) tick();
    uv_flag = 1'b1; tick();
    check(rst_hi === 1'b1, "R2 undervoltage asserts", rst_hi, 1);
    tick(); tick();
    uv_flag = 1'b0;
    n = 0;
    while (rst_hi) begin tick(); n++; end
    check(n == S, "R3 undervoltage stretch", n, S);

    repeat (3) tick();
    mr_n = 1'b0;
    n = 0;
    do begin tick(); n++; end while (!rst_hi && n < 50);
    check(n == G + 3, "R4 manual reset latency", n, G + 3);
    repeat (5) tick();
    mr_n = 1'b1;
    n = 0;
    while (rst_hi) begin tick(); n++; end
    check(n == S + 3, "R6 manual release stretch", n, S + 3);

    repeat (3) tick();
    mr_n = 1'b0;
    repeat (G - 1) tick();
    mr_n = 1'b1;
    seen = 0;
    repeat (30) begin tick(); if (rst_hi) seen = 1; end
    check(!seen, "R5 short dip ignored", seen, 0);

    mr_n = 1'b0;
    repeat (G) tick();
    mr_n = 1'b1;
    seen = 0;
    repeat (2 * G + 4) begin tick(); if (rst_hi) seen = 1; end
    check(seen, "R4 dip of filter length accepted", seen, 1);
    while (rst_hi) tick();

    seen = 0;
    repeat (4 * W) begin tick(); if (rst_hi) seen = 1; end
    check(!seen, "R10 disabled watchdog silent", seen, 0);

    uv_pulse();
    wd_en = 1'b1;
    while (rst_hi) tick();
    count_low(n);
    check(n == W, "R7 first timeout window", n, W);
    count_high(n);
    check(n == S, "R7 timeout pulse length", n, S);
    count_low(n);
    check(n == W, "R9 window after watchdog reset", n, W);
    while (rst_hi) tick();

    repeat (W / 2) tick();
    uv_pulse();
    while (rst_hi) tick();
    count_low(n);
    check(n == W, "R9 full window after undervoltage", n, W);
    while (rst_hi) tick();

    for (int v = 0; v < NV; v++) begin
      bit released;
      uv_pulse();
      released = 0;
      seen = 0;
      for (int i = 0; i < 6 * W; i++) begin
        tick();
        if (released && rst_hi) seen = 1;
        if (!rst_hi) released = 1;
        if (i % GAP[v] == GAP[v] - 1) wd_kick = ~wd_kick;
      end
      check(seen == HIT[v], $sformatf("R8 kick spacing %0d", GAP[v]), seen, HIT[v]);
    end

    wd_en = 1'b0;
    uv_pulse();
    while (rst_hi) tick();
    seen = 0;
    repeat (3 * W) begin tick(); if (rst_hi) seen = 1; end
    check(!seen, "R10 watchdog disabled after use", seen, 0);

    check(compl_bad == 0, "R11 complementary outputs", compl_bad, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule